// File: doc/BRIEF.md
# Seeded Pseudo-Random Word Generator

This peripheral sits on a simple 32-bit register port: a byte address, a write strobe, write data and registered read data. Software loads five 32-bit seed words and then writes a control word that both selects the pseudo-random engine and requests a start. The block then derives five fresh 32-bit output words from the seed material and reports completion through a status register that software polls. There is no interrupt.

The generator treats the five seed words as one 160-bit state. It advances that state with a five-word xorshift recurrence, one step per clock cycle, and records one output word per step. A start request only takes effect when every seed word has been written at least once since reset, the engine-select bit is set and the start bit is set. The start bit never stays set. Software can rewrite three status flags. The remaining status flags are owned by the hardware.

Top module: `seeded_rng_periph`

## Requirements
- R1: After reset, control reads 0x00000000, status reads 0x00000001, and all five output words read 0.
- R2: Status bit 1 (seeds complete) is 1 exactly when each of the five seed words, at byte offsets 0x140 + 4·n for n = 0..4, has been written at least once since reset.
- R3: A write to control (offset 0x00) stores the written value with bit 4 (start) forced to 0, so control never reads back with bit 4 set.
- R4: A control write starts generation only when status bit 1 is 1 and the written value has both bit 3 (engine select) and bit 4 (start) set. Any other control write leaves the output words and status bits 5 and 2 unchanged.
- R5: Generation loads the state s[0..4] from seed words 0..4, where a seed of all zeros is replaced by s[0]=0x2545F491 with the other words 0. Each step computes t = s0 ^ (s0>>2), shifts the words down (s0<-s1 ... s3<-s4), and sets s4 <- s4 ^ (s4<<4) ^ t ^ (t<<1). Output word n (offset 0x160 + 4·n) receives the new s4 after step n+1.
- R6: Status bit 2 (busy) reads 1 in the cycle after an accepted start and clears after five steps, at the same edge where status bit 5 (done) is set. Status bit 0 reads 1 at all times.
- R7: A write to status (offset 0x10) sets bits 5, 4 and 3 to the written values and leaves every other status bit unchanged.
- R8: Reads return 0 at unmapped offsets, at misaligned addresses and at the seed offsets. Writes to unmapped offsets or output offsets change no readable state.
- R9: A start request that arrives while busy is 1 is ignored. Seed writes made during generation do not alter the words that generation produces.
- R10: Read data is registered. bus_rdata shows the value at the address presented before a rising clock edge and holds that value until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 9 | Byte address within the 0x200 region |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bound checker watches several rules on every cycle. It confirms that the buffer-ready bit never drops and that the seeds-complete flag, once set, stays set. It confirms that busy rises only after a qualifying control write and that busy falls only at the edge where done is set. It also confirms that a status write lands on bits 5..3 and that unmapped reads return zero. Other behaviour can only be shown by the bench's scenarios: that the output words match the xorshift sequence for random, zero and partly rewritten seeds, that a start issued while busy is ignored, and that control never reads back its start bit.

// File: rtl/rngp_pkg.sv
package rngp_pkg;
  localparam int WORD_W   = 32;
  localparam int N_WORDS  = 5;
  localparam int ADDR_W   = 9;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 9'h000;
  localparam logic [ADDR_W-1:0] OFF_STAT = 9'h010;
  localparam logic [ADDR_W-1:0] OFF_SEED = 9'h140;
  localparam logic [ADDR_W-1:0] OFF_OUT  = 9'h160;
  localparam int CTRL_SEL_BIT   = 3;
  localparam int CTRL_START_BIT = 4;
  localparam logic [WORD_W-1:0] ZERO_FILL = 32'h2545F491;

  typedef logic [N_WORDS-1:0][WORD_W-1:0] state_t;

  function automatic state_t xs_step(input state_t s);
    state_t n;
    logic [WORD_W-1:0] t;
    t = s[0] ^ (s[0] >> 2);
    for (int i = 0; i < N_WORDS - 1; i++) n[i] = s[i+1];
    n[N_WORDS-1] = s[N_WORDS-1] ^ (s[N_WORDS-1] << 4) ^ t ^ (t << 1);
    return n;
  endfunction
endpackage

// File: rtl/rng_seed_bank.sv
module rng_seed_bank
  import rngp_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = N_WORDS,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [W-1:0]         wr_data,
  output logic [N-1:0][W-1:0]  words,
  output logic                 all_set
);
  logic [N-1:0] written_q;

  for (genvar g = 0; g < N; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        words[g]     <= '0;
        written_q[g] <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        words[g]     <= wr_data;
        written_q[g] <= 1'b1;
      end
    end
  end

  assign all_set = &written_q;
endmodule

// File: rtl/rng_xs_engine.sv
module rng_xs_engine
  import rngp_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = N_WORDS,
  localparam int CNT_W = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [N-1:0][W-1:0]  seeds,
  output logic                 busy,
  output logic                 finish,
  output logic [N-1:0][W-1:0]  outs
);
  state_t             st_q;
  state_t             st_nxt;
  logic [CNT_W-1:0]   cnt_q;

  assign st_nxt = xs_step(st_q);
  assign finish = busy && (cnt_q == CNT_W'(N - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        st_q  <= (seeds == '0) ? state_t'(ZERO_FILL) : seeds;
        cnt_q <= '0;
        busy  <= 1'b1;
      end
    end else begin
      st_q  <= st_nxt;
      cnt_q <= cnt_q + 1'b1;
      if (finish) busy <= 1'b0;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) outs[g] <= '0;
      else if (busy && cnt_q == CNT_W'(g)) outs[g] <= st_nxt[N-1];
    end
  end
endmodule

// File: rtl/seeded_rng_periph.sv
module seeded_rng_periph
  import rngp_pkg::*;
#(
  localparam int W     = WORD_W,
  localparam int N     = N_WORDS,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata
);
  logic [N-1:0][W-1:0] seed_words;
  logic [N-1:0][W-1:0] out_words;
  logic                seeds_full;
  logic                eng_busy, eng_finish;
  logic [W-1:0]        ctrl_q;
  logic [2:0]          sw_flags_q;
  logic [W-1:0]        status_w;

  logic              aligned, hit_seed, hit_out;
  logic [ADDR_W-1:0] seed_rel, out_rel;
  logic [IDX_W-1:0]  seed_idx, out_idx;
  logic              start_req;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign seed_rel = bus_addr - OFF_SEED;
  assign out_rel  = bus_addr - OFF_OUT;
  assign hit_seed = aligned && bus_addr >= OFF_SEED && seed_rel < ADDR_W'(4 * N);
  assign hit_out  = aligned && bus_addr >= OFF_OUT  && out_rel  < ADDR_W'(4 * N);
  assign seed_idx = IDX_W'(seed_rel >> 2);
  assign out_idx  = IDX_W'(out_rel >> 2);

  assign start_req = bus_wr && bus_addr == OFF_CTRL && seeds_full
                  && bus_wdata[CTRL_SEL_BIT] && bus_wdata[CTRL_START_BIT];

  rng_seed_bank #(.W(W), .N(N)) u_seeds (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr && hit_seed), .wr_idx(seed_idx), .wr_data(bus_wdata),
    .words(seed_words), .all_set(seeds_full)
  );

  rng_xs_engine #(.W(W), .N(N)) u_engine (
    .clk(clk), .rst(rst), .start(start_req), .seeds(seed_words),
    .busy(eng_busy), .finish(eng_finish), .outs(out_words)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      sw_flags_q <= '0;
    end else begin
      if (bus_wr && bus_addr == OFF_CTRL) begin
        ctrl_q <= bus_wdata & ~(W'(1) << CTRL_START_BIT);
      end
      if (bus_wr && bus_addr == OFF_STAT) sw_flags_q <= bus_wdata[5:3];
      if (eng_finish) sw_flags_q[2] <= 1'b1;
    end
  end

  assign status_w = {{(W-6){1'b0}}, sw_flags_q, eng_busy, seeds_full, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_addr == OFF_CTRL) begin
      bus_rdata <= ctrl_q;
    end else if (bus_addr == OFF_STAT) begin
      bus_rdata <= status_w;
    end else if (hit_out) begin
      bus_rdata <= out_words[out_idx];
    end else begin
      bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/rng_periph_checker.sv
module rng_periph_checker
  import rngp_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic [WORD_W-1:0] status_w
);
  logic mapped;
  assign mapped = bus_addr == OFF_CTRL || bus_addr == OFF_STAT ||
                  (bus_addr[1:0] == 2'b00 && bus_addr >= OFF_OUT &&
                   bus_addr < OFF_OUT + ADDR_W'(4 * N_WORDS));

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (rst)
    status_w[0]); // R6
  AST_SEEDS_STICKY: assert property (@(posedge clk) disable iff (rst)
    status_w[1] |=> status_w[1]); // R2
  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(status_w[2]) |-> $past(bus_wr && bus_addr == OFF_CTRL && bus_wdata[4]
                                 && bus_wdata[3] && status_w[1])); // R4
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(status_w[2]) |-> status_w[5]); // R6
  AST_STATUS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_STAT && !status_w[2])
      |=> status_w[5:3] == $past(bus_wdata[5:3])); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> bus_rdata == '0); // R8
endmodule

bind seeded_rng_periph rng_periph_checker u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status_w(status_w)
);

// File: tb/seeded_rng_periph_tb.sv
module seeded_rng_periph_tb;
  localparam int CLK_PERIOD = 10;
  typedef logic [4:0][31:0] words_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  words_t m_seed = '0;
  logic [4:0] m_wr = '0;
  logic [31:0] m_ctrl = '0;
  logic [2:0] m_flags = '0;
  words_t m_out = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seeded_rng_periph u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic words_t model_gen(input words_t s0);
    words_t s, res;
    logic [31:0] t;
    s = (s0 == '0) ? words_t'(32'h2545F491) : s0;
    for (int k = 0; k < 5; k++) begin
      t = s[0] ^ (s[0] >> 2);
      s = {s[4] ^ (s[4] << 4) ^ t ^ (t << 1), s[4], s[3], s[2], s[1]};
      res[k] = s[4];
    end
    return res;
  endfunction

  function automatic logic [31:0] model_read(input logic [8:0] a);
    if (a == 9'h000) return m_ctrl;
    if (a == 9'h010) return {26'd0, m_flags, 1'b0, &m_wr, 1'b1};
    if (a[1:0] == 2'b00 && a >= 9'h160 && a < 9'h174) return m_out[(a - 9'h160) >> 2];
    return 32'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [8:0] a);
    logic [31:0] d;
    rd(a, d);
    check(req, d, model_read(a));
  endtask

  task automatic seed_wr(input int n, input logic [31:0] d);
    wr(9'h140 + 9'(4 * n), d);
    m_seed[n] = d; m_wr[n] = 1'b1;
  endtask

  // control write; if accepted, checks busy and then waits for completion
  task automatic ctrl_wr(input logic [31:0] d);
    logic [31:0] s;
    bit go;
    go = (&m_wr) && d[3] && d[4];
    wr(9'h000, d);
    m_ctrl = d & ~32'h10;
    if (go) begin
      rd(9'h010, s);
      check("R6 busy after start", s[2], 1'b1);
      repeat (6) @(negedge clk);
      m_out = model_gen(m_seed);
      m_flags[2] = 1'b1;
    end
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 5; k++) rd_chk(req, 9'h160 + 9'(4 * k));
    rd_chk(req, 9'h010);
    rd_chk(req, 9'h000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, a;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    check_all("R1 reset");

    // R2 partial seeds, start refused (R4)
    for (int k = 0; k < 4; k++) seed_wr(k, $urandom);
    rd_chk("R2 four seeds", 9'h010);
    ctrl_wr(32'h18);
    check_all("R4 start without all seeds");
    seed_wr(4, $urandom);
    rd_chk("R2 all seeds", 9'h010);

    // R3 start bit self-clears; R4 missing select bit
    ctrl_wr(32'hFFFF_FFF7);
    rd(9'h000, d);
    check("R3 start bit readback", d[4], 1'b0);
    check_all("R4 select missing");

    // R5/R6 accepted start
    ctrl_wr(32'h18);
    check_all("R5 outputs");
    rd(9'h010, d);
    check("R6 done set busy clear", d[5:2], 4'b1000);

    // R7 status write
    wr(9'h010, 32'hFFFF_FFC7);
    m_flags = 3'b000;
    rd_chk("R7 status write", 9'h010);
    wr(9'h010, 32'h0000_0038);
    m_flags = 3'b111;
    rd_chk("R7 status set", 9'h010);

    // R9 restart while busy and seed rewrite during generation
    wr(9'h000, 32'h18);
    m_out = model_gen(m_seed);
    wr(9'h140, 32'hDEAD_BEEF);
    wr(9'h000, 32'h1C);
    m_ctrl = 32'h0C;
    m_seed[0] = 32'hDEAD_BEEF;
    repeat (5) @(negedge clk);
    check_all("R9 ignored restart");

    // R5 all-zero seeds
    for (int k = 0; k < 5; k++) seed_wr(k, 32'd0);
    ctrl_wr(32'h18);
    check_all("R5 zero seeds");

    // R8 unmapped, seed offsets and misaligned reads; writes to outputs
    rd_chk("R8 seed read", 9'h144);
    rd_chk("R8 misaligned", 9'h161);
    rd_chk("R8 unmapped", 9'h1FC);
    wr(9'h164, 32'h1234_5678);
    wr(9'h0F0, 32'hFFFF_FFFF);
    check_all("R8 ignored writes");

    // R10 registered read holds until edge
    rd(9'h000, d);
    @(negedge clk);
    bus_addr = 9'h010;
    #1;
    check("R10 read latency", bus_rdata, m_ctrl);

    // random mix
    for (int r = 0; r < 120; r++) begin
      case ($urandom_range(0, 4))
        0: seed_wr($urandom_range(0, 4), ($urandom_range(0, 7) == 0) ? 32'd0 : $urandom);
        1: ctrl_wr($urandom | (($urandom_range(0, 1) == 1) ? 32'h18 : 32'h0));
        2: begin
             d = $urandom;
             wr(9'h010, d);
             m_flags = d[5:3];
           end
        3: begin
             a = 32'(9'h160 + 9'(4 * $urandom_range(0, 4)));
             rd_chk("R5 random output read", a[8:0]);
           end
        default: begin
             a = 32'($urandom_range(0, 511));
             rd_chk("R8 random address read", a[8:0]);
           end
      endcase
    end
    check_all("R5 final");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule